// File: doc/BRIEF.md
# Buck Gate-Drive Sequencer

This block produces the two gate commands of a synchronous buck charger stage: one for the high-side switch and one for the low-side switch. A free-running phase counter, clocked at a known fast rate, divides time into fixed switching periods. At the start of every period the block samples three inputs. The first is a duty code giving the high-side on-time in clock counts. The second is a light-load flag, raised when the charge current is below the synchronous threshold. The third is a flag saying the bootstrap supply of the high-side driver is low. The block then plays out that period's gate pattern.

With the light-load flag clear, the low side is the complement of the high side, and a guard interval with both switches off is inserted at each edge. With the flag set, the low side fires only one short recharge pulse after the high side turns off. This keeps the inductor current from going negative. At full duty the bootstrap capacitor gets no chance to recharge. The block therefore counts the periods in which full duty and a low bootstrap occur together and, after a set number of them, inserts one recharge period. At zero duty nothing switches, apart from a recharge pulse when the bootstrap is low.

Period length, guard interval, recharge pulse width and the limit on consecutive low-bootstrap periods are all parameters given in clock counts. Each output is registered, so it follows the period phase by one clock.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `hiDrive` and `loDrive` are both low.
- R2: The period is exactly `PERIOD_CYC` clocks. `dutyCode`, `lightLoad` and `bootLow` are sampled only at the start of a period, so a change during a period has no effect on the outputs until the next period.
- R3: For a duty code D with 0 < D < `PERIOD_CYC`, the high side is on for the first D clocks of the period and off for the rest.
- R4: A duty code D ≥ `PERIOD_CYC` is full duty. Unless a recharge period is due, the high side is on for the whole period and the low side stays off.
- R5: A duty code of 0 with `bootLow` clear keeps both outputs off for the whole period.
- R6: A duty code of 0 with `bootLow` set produces a single low-side pulse. The pulse is `REFRESH_CYC` clocks long and begins `DEAD_CYC` clocks into the period. The high side stays off.
- R7: With `lightLoad` clear (synchronous mode), the low side is on from D+`DEAD_CYC` until `PERIOD_CYC`−`DEAD_CYC` (exclusive), counted in clocks from the period start.
- R8: With `lightLoad` set (pulse-skipping mode), the low side is on for `REFRESH_CYC` clocks starting at D+`DEAD_CYC`, cut off at `PERIOD_CYC`−`DEAD_CYC`. It then stays off until the next period.
- R9: Count the consecutive periods that start with full duty and `bootLow` set. When `BOOT_LIMIT` of them have passed and the next one also qualifies, that period becomes a recharge period. In it the low side is on over [`DEAD_CYC`, `DEAD_CYC`+`REFRESH_CYC`), and the high side is off until 2·`DEAD_CYC`+`REFRESH_CYC` and on for the rest of the period. The count then restarts from zero. Any period that does not qualify also clears the count.
- R10: The two outputs are never high together. Every rising edge of either output comes at least `DEAD_CYC` clocks after the other output was last high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sequencing clock |
| rst | input | 1 | Synchronous reset, active high |
| dutyCode | input | DUTY_W | High-side on-time in clocks, sampled at period start |
| lightLoad | input | 1 | Charge current below the synchronous threshold (selects pulse-skipping) |
| bootLow | input | 1 | Bootstrap supply of the high-side driver is low |
| hiDrive | output | 1 | High-side gate command |
| loDrive | output | 1 | Low-side gate command |

## Verification
The bench targets the recharge counting. A run of full-duty periods with a low bootstrap must recharge on exactly the fourth qualifying period, and a run broken by one clean period must not recharge at all. An off-by-one counter would move the recharge period or let the high side run with a starved bootstrap. A pulse-skipping duty close to the period end checks that the recharge pulse is cut off before the next high-side edge. Without that cut, the pulse would overlap the following guard interval. Duty codes, mode and bootstrap flags are also toggled in the middle of a period. A design that sampled them at any time other than the period start would cut pulses short or open a shoot-through window.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  // Strobes handed from the period controller to the gate datapath.
  typedef struct packed {
    logic load;       // last clock of a period: latch next period's inputs
    logic asyncMode;  // this period runs pulse-skipping
    logic bootLow;    // bootstrap-low flag latched for this period
    logic refresh;    // this period is a forced bootstrap recharge
  } seq_strobe_t;
endpackage

// File: rtl/buck_seq_ctl.sv
module buck_seq_ctl
  import buck_seq_pkg::*;
#(
  parameter int PERIOD_CYC = 333,
  parameter int DUTY_W     = 9,
  parameter int BOOT_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic              lightLoad,
  input  logic              bootLow,
  output logic [DUTY_W-1:0] phase,
  output seq_strobe_t       strobe
);
  localparam int RUN_W = $clog2(BOOT_LIMIT + 1);
  localparam logic [DUTY_W-1:0] LAST_PH   = DUTY_W'(PERIOD_CYC - 1);
  localparam logic [DUTY_W-1:0] FULL_CODE = DUTY_W'(PERIOD_CYC);
  localparam logic [RUN_W-1:0]  RUN_MAX   = RUN_W'(BOOT_LIMIT);

  logic [DUTY_W-1:0] phaseQ;
  logic [RUN_W-1:0]  runCnt;
  logic              asyncQ, bootQ, refreshQ;
  logic              periodEnd, fullReq;

  assign periodEnd = (phaseQ == LAST_PH);
  assign fullReq   = (dutyCode >= FULL_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ   <= LAST_PH;
      asyncQ   <= 1'b0;
      bootQ    <= 1'b0;
      refreshQ <= 1'b0;
      runCnt   <= '0;
    end else if (periodEnd) begin
      phaseQ <= '0;
      asyncQ <= lightLoad;
      bootQ  <= bootLow;
      if (fullReq && bootLow) begin
        if (runCnt == RUN_MAX) begin
          refreshQ <= 1'b1;
          runCnt   <= '0;
        end else begin
          refreshQ <= 1'b0;
          runCnt   <= runCnt + RUN_W'(1);
        end
      end else begin
        refreshQ <= 1'b0;
        runCnt   <= '0;
      end
    end else begin
      phaseQ <= phaseQ + DUTY_W'(1);
    end
  end

  assign phase  = phaseQ;
  assign strobe = '{load: periodEnd, asyncMode: asyncQ, bootLow: bootQ, refresh: refreshQ};

  // R2: mode and bootstrap flags only move at a period boundary
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> ($stable(asyncQ) && $stable(bootQ)));

  // R9: a recharge period is only ever entered with the bootstrap flag low-latched
  p_refresh_boot_r9: assert property (@(posedge clk) disable iff (rst)
    refreshQ |-> bootQ);
endmodule

// File: rtl/buck_seq_dp.sv
module buck_seq_dp
  import buck_seq_pkg::*;
#(
  parameter int PERIOD_CYC  = 333,
  parameter int DUTY_W      = 9,
  parameter int DEAD_CYC    = 3,
  parameter int REFRESH_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [DUTY_W-1:0] phase,
  input  seq_strobe_t       strobe,
  output logic              hiDrive,
  output logic              loDrive
);
  localparam int SUM_W  = DUTY_W + 2;
  localparam int IDLE_W = $clog2(DEAD_CYC + 1);
  localparam logic [SUM_W-1:0] P_S       = SUM_W'(PERIOD_CYC);
  localparam logic [SUM_W-1:0] DT_S      = SUM_W'(DEAD_CYC);
  localparam logic [SUM_W-1:0] RF_S      = SUM_W'(REFRESH_CYC);
  localparam logic [SUM_W-1:0] LS_LIMIT  = SUM_W'(PERIOD_CYC - DEAD_CYC);
  localparam logic [SUM_W-1:0] PULSE_END = SUM_W'(DEAD_CYC + REFRESH_CYC);
  localparam logic [SUM_W-1:0] REF_HS_ON = SUM_W'(2 * DEAD_CYC + REFRESH_CYC);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(DEAD_CYC);

  logic [DUTY_W-1:0] dutyQ;
  logic [SUM_W-1:0]  ph, dq, onT, lsStart, lsPulseEnd, lsEnd;
  logic              isFull, hsNext, lsNext;
  logic [IDLE_W-1:0] hiIdle, loIdle;

  always_ff @(posedge clk) begin
    if (rst)              dutyQ <= '0;
    else if (strobe.load) dutyQ <= dutyCode;
  end

  always_comb begin
    ph         = SUM_W'(phase);
    dq         = SUM_W'(dutyQ);
    isFull     = (dq >= P_S);
    onT        = isFull ? P_S : dq;
    lsStart    = onT + DT_S;
    lsPulseEnd = lsStart + RF_S;
    if (strobe.asyncMode) lsEnd = (lsPulseEnd < LS_LIMIT) ? lsPulseEnd : LS_LIMIT;
    else                  lsEnd = LS_LIMIT;

    if (strobe.refresh) begin
      hsNext = (ph >= REF_HS_ON);
      lsNext = (ph >= DT_S) && (ph < PULSE_END);
    end else if (dq == '0) begin
      hsNext = 1'b0;
      lsNext = strobe.bootLow && (ph >= DT_S) && (ph < PULSE_END);
    end else if (isFull) begin
      hsNext = 1'b1;
      lsNext = 1'b0;
    end else begin
      hsNext = (ph < onT);
      lsNext = (ph >= lsStart) && (ph < lsEnd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiDrive <= 1'b0;
      loDrive <= 1'b0;
    end else begin
      hiDrive <= hsNext;
      loDrive <= lsNext;
    end
  end

  // Idle-time counters for the guard-interval checks, saturating at DEAD_CYC.
  always_ff @(posedge clk) begin
    if (rst) begin
      hiIdle <= IDLE_MAX;
      loIdle <= IDLE_MAX;
    end else begin
      if (hiDrive)                hiIdle <= '0;
      else if (hiIdle != IDLE_MAX) hiIdle <= hiIdle + IDLE_W'(1);
      if (loDrive)                loIdle <= '0;
      else if (loIdle != IDLE_MAX) loIdle <= loIdle + IDLE_W'(1);
    end
  end

  // R10: no shoot-through
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    !(hiDrive && loDrive));

  // R10: guard interval before each high-side turn-on
  p_hs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(hiDrive) |-> (loIdle == IDLE_MAX));

  // R10: guard interval before each low-side turn-on
  p_ls_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(loDrive) |-> (hiIdle == IDLE_MAX));

  // R5: zero duty with a healthy bootstrap keeps both switches off
  p_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (dutyQ == '0 && !strobe.bootLow) |=> (!hiDrive && !loDrive));

  // R4: full duty outside a recharge period holds the high side on
  p_full_on_r4: assert property (@(posedge clk) disable iff (rst)
    (isFull && !strobe.refresh) |=> (hiDrive && !loDrive));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int PERIOD_CYC  = 333,
  parameter int DUTY_W      = 9,
  parameter int DEAD_CYC    = 3,
  parameter int REFRESH_CYC = 8,
  parameter int BOOT_LIMIT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic              lightLoad,
  input  logic              bootLow,
  output logic              hiDrive,
  output logic              loDrive
);
  logic [DUTY_W-1:0] phase;
  seq_strobe_t       strobe;

  buck_seq_ctl #(
    .PERIOD_CYC(PERIOD_CYC), .DUTY_W(DUTY_W), .BOOT_LIMIT(BOOT_LIMIT)
  ) u_ctl (
    .clk(clk), .rst(rst), .dutyCode(dutyCode), .lightLoad(lightLoad),
    .bootLow(bootLow), .phase(phase), .strobe(strobe)
  );

  buck_seq_dp #(
    .PERIOD_CYC(PERIOD_CYC), .DUTY_W(DUTY_W),
    .DEAD_CYC(DEAD_CYC), .REFRESH_CYC(REFRESH_CYC)
  ) u_dp (
    .clk(clk), .rst(rst), .dutyCode(dutyCode), .phase(phase), .strobe(strobe),
    .hiDrive(hiDrive), .loDrive(loDrive)
  );
endmodule

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
  localparam int P  = 40;
  localparam int W  = 6;
  localparam int DT = 3;
  localparam int RF = 8;
  localparam int LIM = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] dutyCode = '0;
  logic         lightLoad = 1'b0;
  logic         bootLow = 1'b0;
  logic         hiDrive, loDrive;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 0;
  bit finished = 0;

  // reference model state
  int    mPh, mD, mRun;
  bit    mAsync, mBoot, mRef, chg;
  bit    expHs = 0, expLs = 0;
  string expTag = "R1";

  buck_gate_seq #(
    .PERIOD_CYC(P), .DUTY_W(W), .DEAD_CYC(DT), .REFRESH_CYC(RF), .BOOT_LIMIT(LIM)
  ) u0 (
    .clk(clk), .rst(rst), .dutyCode(dutyCode), .lightLoad(lightLoad),
    .bootLow(bootLow), .hiDrive(hiDrive), .loDrive(loDrive)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Behavioural model: decides the pattern for the current phase, then advances.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mPh = P - 1; mD = 0; mAsync = 0; mBoot = 0; mRef = 0; mRun = 0; chg = 0;
      expHs = 0; expLs = 0; expTag = "R1";
    end else begin
      int c, s, e;
      c = mPh;
      if (mRef) begin
        expHs = (c >= 2*DT + RF);
        expLs = (c >= DT) && (c < DT + RF);
        expTag = "R9";
      end else if (mD == 0) begin
        expHs = 0;
        expLs = mBoot && (c >= DT) && (c < DT + RF);
        expTag = mBoot ? "R6" : "R5";
      end else if (mD >= P) begin
        expHs = 1; expLs = 0;
        expTag = "R4";
      end else begin
        expHs = (c < mD);
        s = mD + DT;
        e = P - DT;
        if (mAsync && (s + RF < e)) e = s + RF;
        expLs = (c >= s) && (c < e);
        expTag = mAsync ? "R3/R8" : "R3/R7";
      end
      if (chg) expTag = {"R2 ", expTag};
      if (mPh == P - 1) begin
        mPh = 0;
        mD = int'(dutyCode); mAsync = lightLoad; mBoot = bootLow; chg = 0;
        if (mD >= P && bootLow) begin
          if (mRun == LIM) begin mRef = 1; mRun = 0; end
          else begin mRef = 0; mRun++; end
        end else begin
          mRef = 0; mRun = 0;
        end
      end else begin
        mPh++;
        if (int'(dutyCode) != mD || lightLoad != mAsync || bootLow != mBoot) chg = 1;
      end
    end
    started = 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual cycles=%0d expected under 150000", cyc);
      finishRun();
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (started && !finished) begin
      total++;
      if (hiDrive !== expHs || loDrive !== expLs) begin
        bad++;
        $display("FAIL %s at cycle %0d: actual hi=%0b lo=%0b expected hi=%0b lo=%0b",
                 expTag, cyc, hiDrive, loDrive, expHs, expLs);
      end
      total++;
      if (hiDrive === 1'b1 && loDrive === 1'b1) begin // R10
        bad++;
        $display("FAIL R10 at cycle %0d: actual hi=1 lo=1 expected not both high", cyc);
      end
    end
  end

  task automatic setIn(int d, bit light, bit boot, int periods);
    @(negedge clk);
    dutyCode = W'(d); lightLoad = light; bootLow = boot;
    repeat (periods * P) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    setIn(10, 0, 0, 3);   // R3, R7 synchronous mid duty
    setIn(25, 0, 0, 2);
    setIn(10, 1, 0, 3);   // R8 pulse-skipping
    setIn(30, 1, 0, 2);   // R8 pulse cut at period end
    setIn(0,  0, 0, 2);   // R5
    setIn(0,  1, 1, 2);   // R6
    setIn(40, 0, 0, 2);   // R4
    setIn(40, 0, 1, 10);  // R9 recharge on the fourth qualifying period
    setIn(63, 1, 1, 2);   // R9 broken run follows
    setIn(63, 1, 0, 1);
    setIn(50, 0, 1, 3);
    setIn(1,  0, 0, 2);   // R3 boundary durations
    setIn(39, 1, 0, 2);
    setIn(39, 0, 0, 2);
    for (int i = 0; i < 40; i++) begin // R2 mid-period changes
      @(negedge clk);
      dutyCode  = W'((i * 7) % 50);
      lightLoad = i[0];
      bootLow   = (i % 3) == 0;
      repeat (6) @(negedge clk);
    end
    setIn(20, 0, 0, 1);
    rst = 1;              // R1 reset in mid-run
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2 * P) @(negedge clk);
    finishRun();
  end
endmodule